// File: doc/BRIEF.md
# SPI Slave Packet Queue Transmitter

This block is the slave end of an SPI link that delivers short event packets to a master. A local event strobe carries a command byte and a parameter byte. Each strobe places one packet in a small circular queue. A packet is five bytes long: a two-byte sync word, then the command, the parameter and a check byte.

The master owns both chip select and the serial clock. Every byte it shifts in is full duplex. The master normally sends dummy bytes, and the slave returns queued packet bytes in the order they were stored. When no packet is waiting, the slave returns a filler byte. Each byte the master sends is handed to local logic with a one-cycle strobe. A data-available level can be wired to an interrupt pin on the master.

The serial inputs are brought into the system clock domain through synchronizer stages. All SPI edges are then detected in that domain. The system clock must run at least several times faster than the serial clock.

The byte shifter has two states. SH_OFF is the deselected state: the clock is ignored and the output driver is off. SH_RUN is the selected state. SH_OFF moves to SH_RUN when chip select is low. SH_RUN moves back to SH_OFF when chip select is high.

The packet sequencer tracks which byte is loaded next. Its states are PK_HEAD0, PK_HEAD1, PK_CMD, PK_PARAM, PK_CSUM and PK_TAIL.
- On each byte load, it steps forward one state along the chain PK_HEAD0 → PK_HEAD1 → PK_CMD → PK_PARAM → PK_CSUM → PK_TAIL.
- It stays in PK_HEAD0 and loads filler while the queue is empty.
- A load taken in PK_TAIL pops the finished packet. It then goes to PK_HEAD1 if another packet waits (that load sends the first sync byte), or to PK_HEAD0 if none waits.
- Deselection from any state returns it to PK_HEAD0 and pops nothing.

Top module: `spi_pkt_slave`

## Requirements
- R1: A packet goes out as five bytes in this order: 0xDE, 0xAD, command, parameter, then command XOR parameter. The link uses SPI mode 0, MSB first. MISO changes after falling clock edges and is sampled by the master on rising edges.
- R2: Each cycle with `evt_valid` high stores one packet, unless the queue is full. Packets are sent in the order they were stored, and back-to-back packets follow one another inside a single selection.
- R3: When no packet is waiting, every byte returned to the master is 0xFF.
- R4: Chip select going low restarts byte framing. The next rising clock edge is bit 7 of a new byte, even if a previous selection ended partway through a byte.
- R5: While `spi_cs_n` is high, `spi_miso_en` is low and clock edges produce no received bytes.
- R6: After every eighth rising clock edge in a selection, `rx_valid` is high for exactly one cycle, and `rx_data` holds the byte the master sent, dummy bytes included.
- R7: `tx_ready` pulses once for each byte moved into the output shifter. This happens once at selection and once at the end of each complete byte.
- R8: `data_avail` is high exactly while at least one complete packet remains queued.
- R9: A store attempted while the queue holds `QDEPTH` packets is dropped and sets `overflow`. `overflow` stays set until `ovf_clr` is pulsed, and a clear wins over a set in the same cycle.
- R10: A packet leaves the queue only after all five of its bytes have been shifted out. If selection ends earlier, the next selection sends that packet again from 0xDE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | One-cycle strobe that stores a packet |
| evt_cmd | input | 8 | Command byte for the packet |
| evt_param | input | 8 | Parameter byte for the packet |
| ovf_clr | input | 1 | Clears the overflow flag |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master (0 when not driven) |
| spi_miso_en | output | 1 | Pad driver enable for MISO, high while selected |
| rx_data | output | 8 | Last byte received from the master |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_ready | output | 1 | Pulse when a byte enters the output shifter |
| data_avail | output | 1 | High while a packet is queued |
| overflow | output | 1 | Sticky flag for dropped packets |

## Verification
The assertions assume that the synchronized serial clock never produces two edges closer together than a few system cycles. This makes byte completions and selection loads distinct events. They also assume that chip select does not change during the same synchronized cycle as a clock edge. The bench keeps to both rules. It holds every serial clock half-period for eight system cycles, and it waits a full half-period between any chip select change and the next clock edge. Event strobes and overflow clears are driven one cycle wide, away from the system clock edge.

// File: rtl/spq_pkg.sv
package spq_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] SYNC_HI = 8'hDE;
    localparam logic [BYTE_W-1:0] SYNC_LO = 8'hAD;

    typedef struct packed {
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] param;
    } spq_entry_t;

    typedef enum logic [0:0] {
        SH_OFF,
        SH_RUN
    } sh_state_t;

    typedef enum logic [2:0] {
        PK_HEAD0,
        PK_HEAD1,
        PK_CMD,
        PK_PARAM,
        PK_CSUM,
        PK_TAIL
    } pk_state_t;

endpackage

// File: rtl/spq_sync.sv
module spq_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{INIT}};
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                stg[i] <= stg[i-1];
            end
            stg[0] <= d;
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spq_queue.sv
module spq_queue
    import spq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  spq_entry_t push_data,
    input  logic       pop,
    input  logic       ovf_clr,
    output spq_entry_t head,
    output logic       empty,
    output logic       multi,
    output logic       overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = PW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    spq_entry_t mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic full, push_ok, pop_ok;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign multi   = (count > CW'(1));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) begin
                wptr <= (wptr == LAST_IDX) ? '0 : wptr + PW'(1);
            end
            if (pop_ok) begin
                rptr <= (rptr == LAST_IDX) ? '0 : rptr + PW'(1);
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (ovf_clr) begin
            overflow <= 1'b0;
        end else if (push && full) begin
            overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/spq_shifter.sv
module spq_shifter
    import spq_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_s,
    input  logic            cs_n_s,
    input  logic            mosi_s,
    input  logic [BITS-1:0] tx_byte,
    output logic            load_req,
    output logic            deselect,
    output logic            miso,
    output logic            miso_en,
    output logic [BITS-1:0] rx_data,
    output logic            rx_valid,
    output logic            tx_ready
);
    localparam int BCW = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [BCW-1:0] LAST_BIT = BCW'(BITS - 1);

    sh_state_t st, st_nxt;
    logic sclk_q;
    logic sclk_rise, sclk_fall, byte_done;
    logic [BCW-1:0] bitcnt;
    logic [BITS-1:0] tx_sh, rx_sh;

    assign sclk_rise = sclk_s && !sclk_q;
    assign sclk_fall = !sclk_s && sclk_q;

    always_comb begin
        st_nxt = st;
        unique case (st)
            SH_OFF: if (!cs_n_s) st_nxt = SH_RUN;
            SH_RUN: if (cs_n_s)  st_nxt = SH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= SH_OFF;
            sclk_q <= 1'b0;
        end else begin
            st     <= st_nxt;
            sclk_q <= sclk_s;
        end
    end

    assign byte_done = (st == SH_RUN) && !cs_n_s && sclk_rise && (bitcnt == LAST_BIT);
    assign load_req  = ((st == SH_OFF) && !cs_n_s) || byte_done;
    assign deselect  = (st == SH_RUN) && cs_n_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            tx_ready <= 1'b0;
        end else begin
            rx_valid <= byte_done;
            tx_ready <= load_req;
            if (st == SH_OFF) begin
                bitcnt <= '0;
            end else if (!cs_n_s && sclk_rise) begin
                bitcnt <= (bitcnt == LAST_BIT) ? '0 : bitcnt + BCW'(1);
                rx_sh  <= {rx_sh[BITS-2:0], mosi_s};
            end
            if (byte_done) begin
                rx_data <= {rx_sh[BITS-2:0], mosi_s};
            end
            if (load_req) begin
                tx_sh <= tx_byte;
            end else if ((st == SH_RUN) && !cs_n_s && sclk_fall && (bitcnt != '0)) begin
                tx_sh <= {tx_sh[BITS-2:0], 1'b0};
            end
        end
    end

    assign miso    = tx_sh[BITS-1];
    assign miso_en = (st == SH_RUN);
endmodule

// File: rtl/spq_packer.sv
module spq_packer
    import spq_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FILL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic              deselect,
    input  logic              empty,
    input  logic              multi,
    input  spq_entry_t        head,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              pop
);
    pk_state_t st, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= PK_HEAD0;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        tx_byte = FILL;
        pop     = 1'b0;
        if (load_req) begin
            unique case (st)
                PK_HEAD0: begin
                    if (!empty) begin
                        tx_byte = SYNC_HI;
                        st_nxt  = PK_HEAD1;
                    end
                end
                PK_HEAD1: begin
                    tx_byte = SYNC_LO;
                    st_nxt  = PK_CMD;
                end
                PK_CMD: begin
                    tx_byte = head.cmd;
                    st_nxt  = PK_PARAM;
                end
                PK_PARAM: begin
                    tx_byte = head.param;
                    st_nxt  = PK_CSUM;
                end
                PK_CSUM: begin
                    tx_byte = head.cmd ^ head.param;
                    st_nxt  = PK_TAIL;
                end
                PK_TAIL: begin
                    pop = 1'b1;
                    if (multi) begin
                        tx_byte = SYNC_HI;
                        st_nxt  = PK_HEAD1;
                    end else begin
                        st_nxt  = PK_HEAD0;
                    end
                end
            endcase
        end else if (deselect) begin
            st_nxt = PK_HEAD0;
        end
    end
endmodule

// File: rtl/spi_pkt_slave.sv
module spi_pkt_slave
    import spq_pkg::*;
#(
    parameter int QDEPTH = 4,
    parameter int SYNC_STAGES = 2,
    parameter logic [7:0] IDLE_BYTE = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_valid,
    input  logic [7:0] evt_cmd,
    input  logic [7:0] evt_param,
    input  logic       ovf_clr,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       spi_miso_en,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       tx_ready,
    output logic       data_avail,
    output logic       overflow
);
    logic [2:0] pins_s;
    logic sclk_s, cs_n_s, mosi_s;
    logic load_req, deselect, pop, empty, multi, miso_raw;
    logic [BYTE_W-1:0] tx_byte;
    spq_entry_t head, push_data;

    spq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_sclk, spi_cs_n, spi_mosi}),
        .q(pins_s)
    );
    assign {sclk_s, cs_n_s, mosi_s} = pins_s;

    assign push_data.cmd   = evt_cmd;
    assign push_data.param = evt_param;

    spq_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(evt_valid), .push_data(push_data),
        .pop(pop), .ovf_clr(ovf_clr),
        .head(head), .empty(empty), .multi(multi), .overflow(overflow)
    );

    spq_packer #(.FILL(IDLE_BYTE)) u_packer (
        .clk(clk), .rst_n(rst_n),
        .load_req(load_req), .deselect(deselect),
        .empty(empty), .multi(multi), .head(head),
        .tx_byte(tx_byte), .pop(pop)
    );

    spq_shifter #(.BITS(BYTE_W)) u_shifter (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
        .tx_byte(tx_byte),
        .load_req(load_req), .deselect(deselect),
        .miso(miso_raw), .miso_en(spi_miso_en),
        .rx_data(rx_data), .rx_valid(rx_valid), .tx_ready(tx_ready)
    );

    assign spi_miso   = spi_miso_en & miso_raw;
    assign data_avail = !empty;
endmodule

// File: rtl/spq_checker.sv
module spq_checker (
    input logic clk,
    input logic rst_n,
    input logic evt_valid,
    input logic ovf_clr,
    input logic spi_miso_en,
    input logic rx_valid,
    input logic tx_ready,
    input logic data_avail,
    input logic overflow
);
    assert_rx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_no_rx_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_miso_en |-> !rx_valid);

    assert_txready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);

    assert_ovf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr |=> !overflow);

    assert_pop_on_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_avail) |-> tx_ready);

    assert_avail_from_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_avail) |-> $past(evt_valid));
endmodule

bind spi_pkt_slave spq_checker u_spq_checker (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .ovf_clr(ovf_clr),
    .spi_miso_en(spi_miso_en), .rx_valid(rx_valid), .tx_ready(tx_ready),
    .data_avail(data_avail), .overflow(overflow)
);

// File: tb/spi_pkt_slave_bench.sv
module spi_pkt_slave_bench;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_valid = 1'b0;
    logic [7:0] evt_cmd = '0;
    logic [7:0] evt_param = '0;
    logic ovf_clr = 1'b0;
    logic spi_sclk = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso, spi_miso_en, rx_valid, tx_ready, data_avail, overflow;
    logic [7:0] rx_data;

    int n_tests = 0;
    int n_fail = 0;
    int rx_cnt = 0;
    int txr_cnt = 0;
    logic [7:0] rx_last = '0;

    always #2.5 clk = ~clk;

    spi_pkt_slave u_spi_pkt_slave (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_cmd(evt_cmd),
        .evt_param(evt_param), .ovf_clr(ovf_clr), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_miso_en(spi_miso_en), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_ready(tx_ready), .data_avail(data_avail), .overflow(overflow)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_data;
        end
        if (tx_ready) txr_cnt <= txr_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] c, input logic [7:0] p);
        @(negedge clk);
        evt_cmd = c; evt_param = p; evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic sel();
        spi_cs_n = 1'b0;
        wait_h();
    endtask

    task automatic desel();
        wait_h();
        spi_cs_n = 1'b1;
        wait_h();
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            spi_mosi = 1'b1;
            wait_h(); spi_sclk = 1'b1;
            wait_h(); spi_sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = mo[i];
            wait_h();
            mi[i] = spi_miso;
            spi_sclk = 1'b1;
            wait_h();
            spi_sclk = 1'b0;
        end
        wait_h();
    endtask

    task automatic read_pkt(input string req, input logic [7:0] c, input logic [7:0] p);
        logic [7:0] b;
        xfer(8'hFF, b); chk({req, " sync hi"}, b, 8'hDE);
        xfer(8'hFF, b); chk({req, " sync lo"}, b, 8'hAD);
        xfer(8'hFF, b); chk({req, " cmd"}, b, c);
        xfer(8'hFF, b); chk({req, " param"}, b, p);
        xfer(8'hFF, b); chk({req, " check"}, b, c ^ p);
    endtask

    task automatic t_reset();
        chk("R5 miso_en at reset", spi_miso_en, 0);
        chk("R8 data_avail at reset", data_avail, 0);
        chk("R9 overflow at reset", overflow, 0);
        chk("R6 rx_valid at reset", rx_valid, 0);
    endtask

    task automatic t_idle_fill();
        logic [7:0] b;
        int r0 = rx_cnt;
        int t0 = txr_cnt;
        sel();
        chk("R5 miso_en when selected", spi_miso_en, 1);
        xfer(8'hA5, b);
        chk("R3 filler byte", b, 8'hFF);
        chk("R6 rx byte", rx_last, 8'hA5);
        chk("R6 one strobe", rx_cnt - r0, 1);
        xfer(8'h3C, b);
        chk("R3 filler again", b, 8'hFF);
        chk("R6 second rx byte", rx_last, 8'h3C);
        desel();
        chk("R7 tx_ready count", txr_cnt - t0, 3);
    endtask

    task automatic t_single();
        logic [7:0] b;
        push(8'h12, 8'h34);
        chk("R8 avail after push", data_avail, 1);
        sel();
        read_pkt("R1", 8'h12, 8'h34);
        chk("R8 avail after drain", data_avail, 0);
        xfer(8'h00, b);
        chk("R3 filler after packet", b, 8'hFF);
        desel();
    endtask

    task automatic t_order();
        push(8'h01, 8'h81);
        push(8'h02, 8'h42);
        push(8'h03, 8'hC3);
        sel();
        read_pkt("R2 first", 8'h01, 8'h81);
        read_pkt("R2 second", 8'h02, 8'h42);
        read_pkt("R2 third", 8'h03, 8'hC3);
        desel();
        chk("R8 avail empty", data_avail, 0);
    endtask

    task automatic t_partial();
        logic [7:0] b;
        push(8'h55, 8'h0F);
        sel();
        xfer(8'hFF, b); chk("R10 partial sync hi", b, 8'hDE);
        xfer(8'hFF, b); chk("R10 partial sync lo", b, 8'hAD);
        xfer(8'hFF, b); chk("R10 partial cmd", b, 8'h55);
        desel();
        chk("R5 miso_en off after deselect", spi_miso_en, 0);
        chk("R10 packet kept", data_avail, 1);
        sel();
        read_pkt("R10 resend", 8'h55, 8'h0F);
        chk("R10 popped after five", data_avail, 0);
        desel();
    endtask

    task automatic t_cs_gate();
        int r0 = rx_cnt;
        pulses(8);
        chk("R5 no rx while deselected", rx_cnt - r0, 0);
        chk("R5 miso_en low while deselected", spi_miso_en, 0);
    endtask

    task automatic t_realign();
        logic [7:0] b;
        push(8'hA0, 8'h0A);
        sel();
        pulses(3);
        desel();
        sel();
        xfer(8'h5A, b);
        chk("R4 realigned rx byte", rx_last, 8'h5A);
        chk("R4 realigned first tx byte", b, 8'hDE);
        xfer(8'hFF, b); chk("R4 next byte", b, 8'hAD);
        xfer(8'hFF, b); chk("R4 cmd", b, 8'hA0);
        xfer(8'hFF, b); chk("R4 param", b, 8'h0A);
        xfer(8'hFF, b); chk("R4 check", b, 8'hAA);
        desel();
    endtask

    task automatic t_overflow();
        logic [7:0] b;
        for (int i = 0; i < 4; i++) push(8'(8'h10 + i), 8'(8'h20 + i));
        chk("R9 no overflow when just full", overflow, 0);
        push(8'hEE, 8'hEE);
        chk("R9 overflow set", overflow, 1);
        repeat (5) @(negedge clk);
        chk("R9 overflow sticky", overflow, 1);
        sel();
        for (int i = 0; i < 4; i++) read_pkt("R9 kept", 8'(8'h10 + i), 8'(8'h20 + i));
        xfer(8'hFF, b);
        chk("R9 dropped packet absent", b, 8'hFF);
        desel();
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        @(negedge clk);
        chk("R9 overflow cleared", overflow, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_idle_fill();
        t_single();
        t_order();
        t_partial();
        t_cs_gate();
        t_realign();
        t_overflow();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule